// File: doc/BRIEF.md
# Character Phase Alignment Histogram

This block looks at a captured frame one 32-bit word at a time and finds the pixel phase, inside a repeating character cell, that is blank more often than any other. Each word holds eight 4-bit pixel fields in a fixed, interleaved slot order. For every slot, the low three bits of the field are tested for non-zero. A lit pixel adds one to the counter of the cell phase it falls on. The result is a delay, the cell width minus the phase of the least-lit counter. A sampling stage can use it to move character boundaries onto word boundaries.

Software or a capture sequencer pulses `start_i` before a frame. It then streams words with `word_vld_i`, marks the first word of each line with `line_start_i`, and pulses `frame_done_i` with or after the last word. The block then scans its counters, one per cycle, and raises `done_o` for one cycle when `delay_o` becomes valid. `delay_o` holds that value until the next start. With the default cell width of eight, every word covers exactly one cell, so slot k always lands on counter k. Wider cells make the phase walk across words and lines.

Top module: `char_phase_hist`

## Requirements
- R1: Pixel slots 0..7 of a word are the 3-bit fields at bit offsets 4, 0, 12, 8, 20, 16, 28, 24 in that order. A slot is lit when its 3 bits are non-zero. Bit 3 of each nibble has no effect.
- R2: A lit slot k of an accepted word adds one to counter (phase + k) mod CELL_W. After each accepted word the phase moves forward by 8, modulo CELL_W. With CELL_W = 8, slot k always maps to counter k.
- R3: `line_start_i` sets the phase to 0. A word accepted in the same cycle already uses phase 0.
- R4: Counters saturate at 2^CNT_W - 1 and never wrap.
- R5: The search takes the lowest index holding the minimum count. The delay is CELL_W minus that index, so an index of 0 gives CELL_W.
- R6: The cycle that takes `frame_done_i` still counts a word that is valid in that cycle. `done_o` is high for exactly one cycle, CELL_W clock edges after that cycle's edge.
- R7: `word_vld_i` and `frame_done_i` have no effect from the cycle after frame-done is taken until the next `start_i`.
- R8: `delay_o` holds its value until `start_i`. `start_i` clears all counters, the phase and `delay_o` (to 0), and a word valid in the same cycle is dropped.
- R9: After reset, `done_o` and `delay_o` are 0, all counters are 0 and the block accepts words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears counters, phase and result |
| word_vld_i | input | 1 | `word_i` is valid this cycle |
| word_i | input | 32 | Eight packed 4-bit pixel fields |
| line_start_i | input | 1 | First word of a line; phase returns to 0 |
| frame_done_i | input | 1 | Frame complete; begin the minimum search |
| done_o | output | 1 | One-cycle pulse when `delay_o` is updated |
| delay_o | output | $clog2(CELL_W+1) | Alignment delay, 1..CELL_W once valid |

## Verification
Two of the block's functions can act in the same cycle: counting the final word and starting the search. The bench drives a last word together with `frame_done_i`. That word alone moves the minimum from phase 1 to phase 0, so only a delay of 8 shows that it was counted before the scan began. The bench also pairs `start_i` with a valid word. A delay of 5 instead of 7 shows that the clear took priority and the word was dropped.

// File: rtl/char_phase_hist.sv
module char_phase_hist #(
  parameter int CELL_W = 8,
  parameter int CNT_W  = 16,
  localparam int PH_W  = $clog2(CELL_W),
  localparam int DLY_W = $clog2(CELL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             word_vld_i,
  input  logic [31:0]      word_i,
  input  logic             line_start_i,
  input  logic             frame_done_i,
  output logic             done_o,
  output logic [DLY_W-1:0] delay_o
);

  typedef enum logic [1:0] {ACC, SRCH, HOLD} st_t;

  localparam logic [CNT_W-1:0] CMAX = '1;

  st_t              st_q;
  logic [PH_W-1:0]  phase_q, idx_q, min_idx_q;
  logic [CNT_W-1:0] min_q;
  logic [CNT_W-1:0] cnt_q [CELL_W];
  logic [7:0]       lit;
  logic [CELL_W-1:0] hit;
  logic [PH_W-1:0]  base, next_ph, new_idx;
  logic [CNT_W-1:0] cur;
  logic             take, last_step, busy;

  for (genvar k = 0; k < 8; k++) begin : g_slot
    assign lit[k] = |word_i[(k / 2) * 8 + ((k % 2) ? 0 : 4) +: 3];
  end

  assign base    = line_start_i ? '0 : phase_q;
  assign next_ph = PH_W'((int'(base) + 8) % CELL_W);

  always_comb begin
    hit = '0;
    for (int j = 0; j < CELL_W; j++)
      for (int k = 0; k < 8; k++)
        if ((int'(base) + k) % CELL_W == j) hit[j] = lit[k];
  end

  assign cur       = cnt_q[idx_q];
  assign take      = (idx_q == '0) || (cur < min_q);
  assign new_idx   = take ? idx_q : min_idx_q;
  assign last_step = idx_q == PH_W'(CELL_W - 1);
  assign busy      = st_q == SRCH;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ACC;
      phase_q   <= '0;
      idx_q     <= '0;
      min_idx_q <= '0;
      min_q     <= '0;
      done_o    <= 1'b0;
      delay_o   <= '0;
      for (int j = 0; j < CELL_W; j++) cnt_q[j] <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        st_q    <= ACC;
        phase_q <= '0;
        delay_o <= '0;
        for (int j = 0; j < CELL_W; j++) cnt_q[j] <= '0;
      end else begin
        case (st_q)
          ACC: begin
            if (word_vld_i) begin
              phase_q <= next_ph;
              for (int j = 0; j < CELL_W; j++)
                if (hit[j] && cnt_q[j] != CMAX) cnt_q[j] <= cnt_q[j] + 1'b1;
            end else if (line_start_i) begin
              phase_q <= '0;
            end
            if (frame_done_i) begin
              st_q  <= SRCH;
              idx_q <= '0;
            end
          end
          SRCH: begin
            if (take) min_q <= cur;
            min_idx_q <= new_idx;
            idx_q     <= idx_q + 1'b1;
            if (last_step) begin
              delay_o <= DLY_W'(CELL_W) - DLY_W'(new_idx);
              done_o  <= 1'b1;
              st_q    <= HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/char_phase_hist_chk.sv
module char_phase_hist_chk #(
  parameter int CELL_W = 8,
  localparam int DLY_W = $clog2(CELL_W + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy,
  input logic             done_o,
  input logic [DLY_W-1:0] delay_o
);

  // R6
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  p_done_after_search_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy));

  // R5
  p_delay_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (delay_o >= 1 && int'(delay_o) <= CELL_W));

  // R8
  p_delay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (done_o || $stable(delay_o)));

  // R8
  p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_o && delay_o == '0));

endmodule

bind char_phase_hist char_phase_hist_chk #(.CELL_W(CELL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy(busy),
  .done_o(done_o), .delay_o(delay_o)
);

// File: tb/tb_char_phase_hist.sv
module tb_char_phase_hist;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, vld = 0, ls = 0, fd = 0;
  logic [31:0] word = '0;
  logic        d8_done, d12_done, ds_done;
  logic [3:0]  d8_dly, d12_dly, ds_dly;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  char_phase_hist dut (.clk(clk), .rst_n(rst_n), .start_i(start), .word_vld_i(vld),
    .word_i(word), .line_start_i(ls), .frame_done_i(fd), .done_o(d8_done), .delay_o(d8_dly));

  char_phase_hist #(.CELL_W(12)) dut12 (.clk(clk), .rst_n(rst_n), .start_i(start),
    .word_vld_i(vld), .word_i(word), .line_start_i(ls), .frame_done_i(fd),
    .done_o(d12_done), .delay_o(d12_dly));

  char_phase_hist #(.CNT_W(2)) dut_sat (.clk(clk), .rst_n(rst_n), .start_i(start),
    .word_vld_i(vld), .word_i(word), .line_start_i(ls), .frame_done_i(fd),
    .done_o(ds_done), .delay_o(ds_dly));

  localparam logic [35:0] VEC [8] = '{
    {32'h77777077, 4'd5}, {32'h00000000, 4'd8}, {32'h888888F8, 4'd7},
    {32'h70777777, 4'd1}, {32'h07777777, 4'd2}, {32'h77777707, 4'd8},
    {32'h77777770, 4'd7}, {32'h77700777, 4'd6}};

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(bit st, bit v, logic [31:0] w, bit l, bit f);
    @(negedge clk);
    start = st; vld = v; word = w; ls = l; fd = f;
  endtask

  task automatic wait_done(int which, output int lat);
    logic d;
    lat = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      start = 0; vld = 0; ls = 0; fd = 0;
      lat++;
      d = (which == 0) ? d8_done : (which == 1) ? d12_done : ds_done;
      if (d) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 done after reset", d8_done, 0);
    chk("R9 delay after reset", d8_dly, 0);
    drive(0, 0, 0, 0, 1);
    wait_done(0, lat);
    chk("R9 cleared counters give index 0", d8_dly, 8);

    // R1 R2 R5 R6: table of single-word frames
    foreach (VEC[v]) begin
      drive(1, 0, 0, 0, 0);
      for (int r = 0; r < 3; r++) drive(0, 1, VEC[v][35:4], r == 0, 0);
      drive(0, 0, 0, 0, 1);
      wait_done(0, lat);
      chk("R1 R5 table delay", d8_dly, VEC[v][3:0]);
      chk("R6 latency", lat - 1, 8);
    end

    // R6 one-cycle pulse, R8 hold, R7 frame_done/word in hold ignored
    @(negedge clk);
    chk("R6 done drops", d8_done, 0);
    drive(0, 1, 32'h00000000, 1, 1);
    drive(0, 0, 0, 0, 0);
    repeat (12) @(negedge clk);
    chk("R7 no done in hold", d8_done, 0);
    chk("R8 delay held", d8_dly, 6);
    drive(1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 start clears delay", d8_dly, 0);

    // R6 word with frame_done is counted
    drive(0, 1, 32'h77777770, 1, 0);
    drive(0, 1, 32'h0000000F, 0, 1);
    wait_done(0, lat);
    chk("R6 last word counted", d8_dly, 8);

    // R7 words during search ignored
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 32'h77777077, 1, 0);
    drive(0, 0, 0, 0, 1);
    for (int r = 0; r < 3; r++) drive(0, 1, 32'h00000700, 0, 0);
    wait_done(0, lat);
    chk("R7 search ignores words", d8_dly, 5);

    // R8 word with start dropped
    drive(1, 1, 32'h77777770, 1, 0);
    drive(0, 1, 32'h77777077, 1, 0);
    drive(0, 0, 0, 0, 1);
    wait_done(0, lat);
    chk("R8 start drops word", d8_dly, 5);

    // R4 saturation on 2-bit counters
    drive(1, 0, 0, 0, 0);
    for (int r = 0; r < 4; r++) drive(0, 1, 32'h77777777, 1, 0);
    drive(0, 1, 32'h77777770, 1, 0);
    drive(0, 0, 0, 0, 1);
    wait_done(2, lat);
    chk("R4 counters saturate", ds_dly, 8);

    // R3 line start resets phase on 12-wide cell
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 32'h77777777, 1, 0);
    drive(0, 1, 32'h77777777, 1, 0);
    drive(0, 0, 0, 0, 1);
    wait_done(1, lat);
    chk("R3 line start phase zero", d12_dly, 4);
    chk("R6 latency wide cell", lat - 1, 12);

    // R2 phase advance across words without line start
    drive(1, 0, 0, 0, 0);
    drive(0, 1, 32'h77777777, 1, 0);
    drive(0, 1, 32'h77777777, 0, 0);
    drive(0, 0, 0, 0, 1);
    wait_done(1, lat);
    chk("R2 phase wraps modulo cell", d12_dly, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule